// File: doc/BRIEF.md
# Three-Line Vertical Flicker Filter

This block sits in a graphics-to-television path and softens interlace flicker. Every output pixel is a weighted blend of the pixel at the same column in the line above, the current line and the line below. The block keeps the two previous lines in on-chip line stores. It delivers exactly one output pixel per input pixel, with a fixed delay of one line plus one clock. The data-enable and both sync flags travel through the same stores, so they stay aligned with the pixels.

Four modes set the strength: strong blend, mild blend, straight pass-through, and a built-in colour-bar pattern used for setting up a display. A single debounced push-button input steps through the modes in a ring. A force input, driven by a control register or a sync-command decoder, can impose any mode. While the force is active, the button still moves the underlying selection.

Top module: `vflicker_filter`

## Requirements
- R1: `modeOut` shows the effective mode with the encoding 0 = high, 1 = medium, 2 = off, 3 = colour bars. Reset selects 0 (high).
- R2: A rising edge on `modeToggle` that stays stable for `DEBOUNCE` clocks advances the selected mode by one, in the ring 0→1→2→3→0. A pulse shorter than `DEBOUNCE` clocks is ignored.
- R3: While `forceEn` is 1, `modeOut` equals `forceMode` one clock later, and toggles still advance the hidden selection. When `forceEn` drops, that selection reappears on `modeOut`.
- R4: Output flags `outDe`, `outHs` and `outVs` reproduce the input flags sampled `H_TOTAL+1` clock edges earlier. Every input line must be exactly `H_TOTAL` clocks long.
- R5: In high mode each channel is min(255, (P + 2C + N + 2) >> 2). C is the current pixel, P the pixel one line earlier and N the pixel one line later. Channels are packed as R = [23:16], G = [15:8], B = [7:0].
- R6: In medium mode each channel is min(255, (P + 6C + N + 4) >> 3).
- R7: In off mode the output pixel equals the current input pixel unchanged.
- R8: When the neighbour line above or below had data-enable low at that column, or did not exist since reset, the current pixel replaces it in the blend.
- R9: In colour-bar mode the active line is split into eight equal bars. Bar k covers active pixel positions with k = min(7, pos·8 / `H_ACTIVE`). The bars are white, yellow, cyan, green, magenta, red, blue, black. Each lit channel is 191 and each unlit channel is 0.
- R10: Whenever `outDe` is 0, `outRgb` is 0. This includes the first `H_TOTAL+1` clocks after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inDe | input | 1 | Input data enable (active pixel) |
| inHs | input | 1 | Input horizontal sync flag |
| inVs | input | 1 | Input vertical sync flag |
| inRgb | input | 24 | Input pixel, R/G/B 8 bits each |
| modeToggle | input | 1 | Mode-step push button (raw) |
| forceEn | input | 1 | Override the button selection |
| forceMode | input | 2 | Mode imposed while forced |
| outDe | output | 1 | Delayed data enable |
| outHs | output | 1 | Delayed horizontal sync |
| outVs | output | 1 | Delayed vertical sync |
| outRgb | output | 24 | Filtered or pattern pixel |
| modeOut | output | 2 | Effective mode |

## Verification
The stream combines four picture patterns with all four modes.
- Random pixels check the arithmetic of each blend.
- Lines alternating between 0 and 255 separate the high weights from the medium weights by their very different results.
- A full-white frame probes the saturation limit.
- A lone bright line shows the spread to its two neighbours.
- The top and bottom active lines of every frame exercise edge replication.

Button tests cover the full ring with wrap-around, a glitch that must not count, and stepping under force with recovery when the force is released.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [1:0] {
    MODE_HIGH = 2'd0,
    MODE_MED  = 2'd1,
    MODE_OFF  = 2'd2,
    MODE_BARS = 2'd3
  } flk_mode_e;

  typedef struct packed {
    logic selHigh;
    logic selMed;
    logic selOff;
    logic selBars;
  } flk_strobe_t;

  localparam logic [7:0] BAR_LEVEL = 8'd191;

  // Word layout stored in the line buffers.
  localparam int WORD_W = 27;
  localparam int DE_BIT = 24;
  localparam int HS_BIT = 25;
  localparam int VS_BIT = 26;

endpackage

// File: rtl/flk_ctrl.sv
module flk_ctrl
  import flk_pkg::*;
#(
  parameter int DEBOUNCE = 262144
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeToggle,
  input  logic        forceEn,
  input  logic [1:0]  forceMode,
  output flk_strobe_t strb,
  output logic [1:0]  modeOut,
  output logic [1:0]  selMode,
  output logic        stepPulse
);
  localparam int CW = $clog2(DEBOUNCE + 1);

  logic          syncA, syncB;
  logic          stable;
  logic [CW-1:0] cnt;
  logic          settle;

  assign settle = (syncB != stable) && (cnt == CW'(DEBOUNCE - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA     <= 1'b0;
      syncB     <= 1'b0;
      stable    <= 1'b0;
      cnt       <= '0;
      stepPulse <= 1'b0;
    end else begin
      syncA     <= modeToggle;
      syncB     <= syncA;
      stepPulse <= settle && syncB;
      if (syncB != stable) begin
        if (settle) begin
          stable <= syncB;
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // Ring order high -> medium -> off -> bars -> high.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selMode <= MODE_HIGH;
      modeOut <= MODE_HIGH;
    end else begin
      if (stepPulse) selMode <= selMode + 2'd1;
      modeOut <= forceEn ? forceMode : selMode;
    end
  end

  always_comb begin
    strb.selHigh = (modeOut == MODE_HIGH);
    strb.selMed  = (modeOut == MODE_MED);
    strb.selOff  = (modeOut == MODE_OFF);
    strb.selBars = (modeOut == MODE_BARS);
  end

endmodule

// File: rtl/flk_linebuf.sv
module flk_linebuf #(
  parameter int W     = 27,
  parameter int DEPTH = 800,
  parameter int TAPS  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic [AW-1:0]           addr,
  input  logic [W-1:0]            wrData,
  output logic [TAPS-1:0][W-1:0]  tapOut
);
  logic [TAPS:0][W-1:0] chain;
  assign chain[0] = wrData;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [W-1:0] store [DEPTH];
    logic [W-1:0] rdReg;

    // Read-before-write: the old word at addr is one line older.
    assign chain[k+1] = store[addr];

    always_ff @(posedge clk) begin
      store[addr] <= chain[k];
      rdReg       <= chain[k+1];
    end

    assign tapOut[k] = rdReg;
  end

endmodule

// File: rtl/flk_datapath.sv
module flk_datapath
  import flk_pkg::*;
#(
  parameter int H_TOTAL  = 800,
  parameter int H_ACTIVE = 640
) (
  input  logic        clk,
  input  logic        rstN,
  input  flk_strobe_t strb,
  input  logic        inDe,
  input  logic        inHs,
  input  logic        inVs,
  input  logic [23:0] inRgb,
  output logic        outDe,
  output logic        outHs,
  output logic        outVs,
  output logic [23:0] outRgb
);
  localparam int AW = $clog2(H_TOTAL);
  localparam int PW = $clog2(H_ACTIVE + 1);

  logic [AW-1:0] addr;
  logic [1:0]    fill;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
      fill <= 2'd0;
    end else if (addr == AW'(H_TOTAL - 1)) begin
      addr <= '0;
      if (fill != 2'd2) fill <= fill + 2'd1;
    end else begin
      addr <= addr + AW'(1);
    end
  end

  logic [WORD_W-1:0]          wrWord;
  logic [1:0][WORD_W-1:0]     taps;
  assign wrWord = {inVs, inHs, inDe, inRgb};

  flk_linebuf #(.W(WORD_W), .DEPTH(H_TOTAL), .TAPS(2)) u_lb (
    .clk    (clk),
    .addr   (addr),
    .wrData (wrWord),
    .tapOut (taps)
  );

  // Stage 1: align next (fresh input), current (1 line) and previous (2 lines).
  logic [24:0] nextWord;
  logic        curOk, prevOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextWord <= '0;
      curOk    <= 1'b0;
      prevOk   <= 1'b0;
    end else begin
      nextWord <= {inDe, inRgb};
      curOk    <= (fill != 2'd0);
      prevOk   <= (fill == 2'd2);
    end
  end

  logic [WORD_W-1:0] curWord, prevWord;
  assign curWord  = taps[0];
  assign prevWord = taps[1];

  logic unusedPrevFlags;
  assign unusedPrevFlags = ^prevWord[VS_BIT:HS_BIT];

  logic curDe, prevDe, nextDe;
  assign curDe  = curOk  & curWord[DE_BIT];
  assign prevDe = prevOk & prevWord[DE_BIT];
  assign nextDe = nextWord[DE_BIT];

  // Edge replication: a missing neighbour is replaced by the centre line.
  logic [23:0] upRgb, dnRgb, midRgb;
  assign midRgb = curWord[23:0];
  assign upRgb  = prevDe ? prevWord[23:0] : midRgb;
  assign dnRgb  = nextDe ? nextWord[23:0] : midRgb;

  function automatic logic [7:0] sat8(input logic [11:0] v);
    return (v > 12'd255) ? 8'd255 : v[7:0];
  endfunction

  logic [23:0] highRgb, medRgb;

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [7:0]  pV, cV, nV;
    logic [11:0] sumHigh, sumMed;
    assign pV = upRgb [8*ch +: 8];
    assign cV = midRgb[8*ch +: 8];
    assign nV = dnRgb [8*ch +: 8];
    assign sumHigh = 12'(pV) + {3'b000, cV, 1'b0} + 12'(nV) + 12'd2;
    assign sumMed  = 12'(pV) + 12'(cV) * 12'd6 + 12'(nV) + 12'd4;
    assign highRgb[8*ch +: 8] = sat8(sumHigh >> 2);
    assign medRgb [8*ch +: 8] = sat8(sumMed  >> 3);
  end

  // Colour-bar position within the active part of the current line.
  logic [PW-1:0] posCnt;
  always_ff @(posedge clk) begin
    if (!rstN)      posCnt <= '0;
    else if (curDe) posCnt <= posCnt + PW'(1);
    else            posCnt <= '0;
  end

  logic [2:0]  barSel;
  logic [23:0] barRgb;
  always_comb begin
    int barI;
    barI = (int'(posCnt) * 8) / H_ACTIVE;
    if (barI > 7) barI = 7;
    barSel = barI[2:0];
    barRgb = {(barSel[1] == 1'b0) ? BAR_LEVEL : 8'd0,
              (barSel[2] == 1'b0) ? BAR_LEVEL : 8'd0,
              (barSel[0] == 1'b0) ? BAR_LEVEL : 8'd0};
  end

  // Stage 2: mode select and output register.
  logic [23:0] pixSel;
  always_comb begin
    if (!curDe)            pixSel = '0;
    else if (strb.selBars) pixSel = barRgb;
    else if (strb.selOff)  pixSel = midRgb;
    else if (strb.selMed)  pixSel = medRgb;
    else if (strb.selHigh) pixSel = highRgb;
    else                   pixSel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outDe  <= 1'b0;
      outHs  <= 1'b0;
      outVs  <= 1'b0;
      outRgb <= '0;
    end else begin
      outDe  <= curDe;
      outHs  <= curOk & curWord[HS_BIT];
      outVs  <= curOk & curWord[VS_BIT];
      outRgb <= pixSel;
    end
  end

endmodule

// File: rtl/vflicker_filter.sv
module vflicker_filter
  import flk_pkg::*;
#(
  parameter int H_TOTAL  = 800,
  parameter int H_ACTIVE = 640,
  parameter int DEBOUNCE = 262144
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inDe,
  input  logic        inHs,
  input  logic        inVs,
  input  logic [23:0] inRgb,
  input  logic        modeToggle,
  input  logic        forceEn,
  input  logic [1:0]  forceMode,
  output logic        outDe,
  output logic        outHs,
  output logic        outVs,
  output logic [23:0] outRgb,
  output logic [1:0]  modeOut
);
  flk_strobe_t ctrlStrb;
  logic [1:0]  selMode;
  logic        stepPulse;

  flk_ctrl #(.DEBOUNCE(DEBOUNCE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeToggle (modeToggle),
    .forceEn    (forceEn),
    .forceMode  (forceMode),
    .strb       (ctrlStrb),
    .modeOut    (modeOut),
    .selMode    (selMode),
    .stepPulse  (stepPulse)
  );

  flk_datapath #(.H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (ctrlStrb),
    .inDe   (inDe),
    .inHs   (inHs),
    .inVs   (inVs),
    .inRgb  (inRgb),
    .outDe  (outDe),
    .outHs  (outHs),
    .outVs  (outVs),
    .outRgb (outRgb)
  );

endmodule

// File: rtl/flk_checker.sv
module flk_checker (
  input logic        clk,
  input logic        rstN,
  input logic        forceEn,
  input logic [1:0]  forceMode,
  input logic [1:0]  modeOut,
  input logic [1:0]  selMode,
  input logic        stepPulse,
  input logic        outDe,
  input logic [23:0] outRgb
);
  p_step_ring_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |=> (selMode == $past(selMode) + 2'd1));

  p_hold_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepPulse |=> $stable(selMode));

  p_force_r3: assert property (@(posedge clk) disable iff (!rstN)
    forceEn |=> (modeOut == $past(forceMode)));

  p_blank_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outDe |-> (outRgb == 24'd0));

  p_bar_levels_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outDe && $past(modeOut) == 2'd3) |->
      ((outRgb[23:16] == 8'd0 || outRgb[23:16] == 8'd191) &&
       (outRgb[15:8]  == 8'd0 || outRgb[15:8]  == 8'd191) &&
       (outRgb[7:0]   == 8'd0 || outRgb[7:0]   == 8'd191)));

endmodule

bind vflicker_filter flk_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .forceEn   (forceEn),
  .forceMode (forceMode),
  .modeOut   (modeOut),
  .selMode   (selMode),
  .stepPulse (stepPulse),
  .outDe     (outDe),
  .outRgb    (outRgb)
);

// File: tb/vflicker_filter_tb.sv
`timescale 1ns/1ps
module vflicker_filter_tb;
  localparam int HT = 20;
  localparam int HA = 16;
  localparam int VT = 8;
  localparam int FRAMES = 16;
  localparam int NCYC = FRAMES * HT * VT + 3 * HT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inDe = 1'b0, inHs = 1'b0, inVs = 1'b0;
  logic [23:0] inRgb = '0;
  logic modeToggle = 1'b0, forceEn = 1'b0;
  logic [1:0] forceMode = 2'd0;
  logic outDe, outHs, outVs;
  logic [23:0] outRgb;
  logic [1:0] modeOut;

  always #2.5 clk = ~clk;

  vflicker_filter #(.H_TOTAL(HT), .H_ACTIVE(HA), .DEBOUNCE(4)) u_dut (
    .clk(clk), .rstN(rstN), .inDe(inDe), .inHs(inHs), .inVs(inVs),
    .inRgb(inRgb), .modeToggle(modeToggle), .forceEn(forceEn),
    .forceMode(forceMode), .outDe(outDe), .outHs(outHs), .outVs(outVs),
    .outRgb(outRgb), .modeOut(modeOut));

  int checkCnt = 0;
  int failCnt = 0;

  logic        hDe [NCYC];
  logic        hHs [NCYC];
  logic        hVs [NCYC];
  logic [23:0] hRgb [NCYC];
  logic [1:0]  modeAt [NCYC];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic press(input int hold);
    modeToggle = 1'b1;
    cyc(hold);
    modeToggle = 1'b0;
    cyc(12);
  endtask

  function automatic logic [7:0] blend(input int p, input int c, input int n, input logic [1:0] m);
    int v;
    if (m == 2'd0) v = (p + 2 * c + n + 2) >> 2;
    else           v = (p + 6 * c + n + 4) >> 3;
    if (v > 255) v = 255;
    return 8'(v);
  endfunction

  function automatic logic [23:0] expRgb(input int s);
    logic [1:0]  m;
    logic [23:0] cur, up, dn, res;
    int pos, idx, k;
    if (!hDe[s]) return 24'd0;
    m   = modeAt[s + HT];
    cur = hRgb[s];
    up  = (s >= HT && hDe[s - HT]) ? hRgb[s - HT] : cur;
    dn  = hDe[s + HT] ? hRgb[s + HT] : cur;
    if (m == 2'd2) return cur;
    if (m == 2'd3) begin
      pos = 0;
      k = s - 1;
      while (k >= 0 && hDe[k]) begin pos++; k--; end
      idx = pos * 8 / HA;
      if (idx > 7) idx = 7;
      res[23:16] = ((idx & 2) == 0) ? 8'd191 : 8'd0;
      res[15:8]  = (idx < 4) ? 8'd191 : 8'd0;
      res[7:0]   = ((idx & 1) == 0) ? 8'd191 : 8'd0;
      return res;
    end
    for (int ch = 0; ch < 3; ch++)
      res[8*ch +: 8] = blend(int'(up[8*ch +: 8]), int'(cur[8*ch +: 8]), int'(dn[8*ch +: 8]), m);
    return res;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < NCYC; n++) begin
      int col, line, frm, pat;
      col  = n % HT;
      line = (n / HT) % VT;
      frm  = n / (HT * VT);
      pat  = (frm / 4) % 4;
      hDe[n] = (frm < FRAMES) && col < HA && line >= 1 && line <= 6;
      hHs[n] = (col == HA + 1) || (col == HA + 2);
      hVs[n] = (line == 7);
      modeAt[n] = 2'(frm % 4);
      case (pat)
        0: hRgb[n] = 24'($urandom);
        1: hRgb[n] = (line % 2 == 1) ? 24'hFFFFFF : 24'h000000;
        2: hRgb[n] = 24'hFFFFFF;
        default: hRgb[n] = (line == 3) ? 24'hFFFFFF : 24'h000000;
      endcase
      if (!hDe[n]) hRgb[n] = 24'($urandom);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    // ---- Phase A: reset state and mode control ----
    cyc(4);
    check(modeOut == 2'd0, "R1 reset mode", 32'(modeOut), 0);
    check(outDe == 1'b0 && outRgb == 24'd0, "R10 reset outputs", 32'(outRgb), 0);
    rstN = 1'b1;
    cyc(3);
    check(outRgb == 24'd0 && !outHs && !outVs, "R10 idle outputs", 32'(outRgb), 0);
    press(12);
    check(modeOut == 2'd1, "R2 step to medium", 32'(modeOut), 1);
    press(2);
    check(modeOut == 2'd1, "R2 glitch ignored", 32'(modeOut), 1);
    press(12);
    check(modeOut == 2'd2, "R2 step to off", 32'(modeOut), 2);
    press(12);
    check(modeOut == 2'd3, "R2 step to bars", 32'(modeOut), 3);
    press(12);
    check(modeOut == 2'd0, "R2 wrap to high", 32'(modeOut), 0);
    press(12);
    check(modeOut == 2'd1, "R1 medium shown", 32'(modeOut), 1);
    forceEn = 1'b1;
    forceMode = 2'd3;
    cyc(2);
    check(modeOut == 2'd3, "R3 force applied", 32'(modeOut), 3);
    press(12);
    check(modeOut == 2'd3, "R3 force holds", 32'(modeOut), 3);
    forceEn = 1'b0;
    cyc(2);
    check(modeOut == 2'd2, "R3 hidden step restored", 32'(modeOut), 2);

    // ---- Phase B: video stream against the model ----
    forceEn = 1'b1;
    rstN = 1'b0;
    cyc(3);
    rstN = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      int s;
      inDe = hDe[n];
      inHs = hHs[n];
      inVs = hVs[n];
      inRgb = hRgb[n];
      forceMode = modeAt[n];
      cyc(1);
      s = n - HT - 1;
      if (s < 0) begin
        check(!outDe && !outHs && !outVs && outRgb == 24'd0, "R10 blank after reset",
              32'(outRgb), 0);
      end else begin
        logic [23:0] e;
        string tag;
        e = expRgb(s);
        check(outDe == hDe[s] && outHs == hHs[s] && outVs == hVs[s], "R4 flag delay",
              32'({outVs, outHs, outDe}), 32'({hVs[s], hHs[s], hDe[s]}));
        if (!hDe[s]) tag = "R10 blank pixel";
        else if (s < HT || !hDe[s - HT] || !hDe[s + HT]) tag = "R8 edge line";
        else case (modeAt[s + HT])
          2'd0: tag = "R5 high blend";
          2'd1: tag = "R6 medium blend";
          2'd2: tag = "R7 pass-through";
          default: tag = "R9 colour bars";
        endcase
        check(outRgb == e, tag, 32'(outRgb), 32'(e));
      end
    end
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule